// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This unit performs the data-processing step of a small integer core. Each cycle it takes a 5-bit operation code and two 32-bit operands and produces a 32-bit result, a write-enable for that result, and the next value of a four-bit condition-flag set (negative, zero, carry, overflow). The flags live in a register inside the unit. Carry-consuming operations read that register, and it is loaded on the clock edge whenever an accepted operation changes the flags. The operand path is purely combinational. Operand selection, shifting and register-file access belong to the surrounding pipeline.

Operations enter as a plain valid strobe. There is no back-pressure: the unit completes an operation in the cycle it is presented, so it has no ready signal and any cycle may carry a new operation. Flag bits are packed as {N, Z, C, V} in bits 3 down to 0. On every flag-writing operation, N is result bit 31 and Z is set when the result is zero. Arithmetic operations also write C and V. Logical operations and multiply leave C and V untouched.

Top module: `flag_alu`

## Requirements
- R1: Codes 0 (add) and 6 (compare-negative) compute a + b; C is the unsigned carry out of bit 31 and V the signed overflow of the addition.
- R2: Codes 2 (subtract) and 5 (compare) compute a - b; C is 1 when no unsigned borrow occurs (a >= b) and 0 otherwise; V is the signed overflow of the subtraction.
- R3: Code 1 (add-with-carry) computes a + b + C, using the registered C flag, with flags as in R1.
- R4: Code 3 (subtract-with-carry) computes a - b - (1 - C), so a clear C subtracts one more; C is 1 when the subtraction does not borrow.
- R5: Code 4 (negate) computes 0 - b with subtraction flags; C is 1 only when b is zero.
- R6: Codes 5, 6 and 7 (compare, compare-negative, test a AND b) keep res_we low but still update the flags.
- R7: Codes 7 (test), 8 (AND), 9 (EOR), 10 (ORR), 11 (a AND NOT b), 12 (NOT b), 13 (move: result = b) and 14 (multiply) write only N and Z; C and V keep their previous value.
- R8: Code 14 returns the low 32 bits of the product a * b.
- R9: flags_q loads flags_nxt on a rising edge where op_valid is high and the code is defined; otherwise it holds its value.
- R10: An active-low reset clears flags_q to 4'b0000.
- R11: Codes 15 to 31 give res_we low, and flags_nxt equals flags_q.
- R12: res_we is high only when op_valid is high and the code writes a result (0-4, 8-14); N is bit 3, Z bit 2, C bit 1 and V bit 0 of both flag ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation selector |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (immediate for the move code) |
| res_data | output | 32 | Operation result |
| res_we | output | 1 | Result should be written back |
| flags_nxt | output | 4 | Flags that the current operation produces {N,Z,C,V} |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The main function is driven with a chained list of operations in which each operation inherits the flags of the previous one. Additions that wrap to zero separate carry from overflow. Additions that cross from positive to negative separate overflow from carry. Subtractions with equal, smaller and larger subtrahends check that carry means no borrow. The carry-using codes are run once with C set and once with C clear, to show that the incoming flag is consumed. Logical codes run after C and V have both been set, so any disturbance of those two bits is seen. Compare codes, undefined codes and idle cycles then show that the result enable and the flag register stay quiet.

// File: rtl/falu_pkg.sv
package falu_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 5;
  localparam int FLAG_W = 4;
  localparam int FLG_N  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_C  = 1;
  localparam int FLG_V  = 0;

  typedef enum logic [CODE_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_NEG  = 5'd4,
    OP_CMP  = 5'd5,
    OP_CMN  = 5'd6,
    OP_TST  = 5'd7,
    OP_AND  = 5'd8,
    OP_EOR  = 5'd9,
    OP_ORR  = 5'd10,
    OP_BIC  = 5'd11,
    OP_MVN  = 5'd12,
    OP_MOVI = 5'd13,
    OP_MUL  = 5'd14
  } op_e;

  localparam logic [CODE_W-1:0] LAST_CODE = 5'd14;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_LOGIC = 2'd2
  } cls_e;
endpackage

// File: rtl/falu_adder.sv
module falu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int FW = W + 1;
  logic [FW-1:0] full;

  assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
  // overflow: operands share a sign that the sum does not
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/falu_logic.sv
module falu_logic #(
  parameter int W = 32
) (
  input  falu_pkg::op_e op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  res
);
  import falu_pkg::*;
  logic [W-1:0] prod_lo;

  assign prod_lo = a * b;

  always_comb begin
    unique case (op)
      OP_TST,
      OP_AND:  res = a & b;
      OP_EOR:  res = a ^ b;
      OP_ORR:  res = a | b;
      OP_BIC:  res = a & ~b;
      OP_MVN:  res = ~b;
      OP_MOVI: res = b;
      OP_MUL:  res = prod_lo;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/falu_flagreg.sv
module falu_flagreg #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [FW-1:0] flags_in,
  output logic [FW-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_in;
  end

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> flags_q == $past(flags_q));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> flags_q == $past(flags_in));
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int DW = falu_pkg::DATA_W,
  parameter int CW = falu_pkg::CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [CW-1:0] op_code,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] res_data,
  output logic          res_we,
  output logic [3:0]    flags_nxt,
  output logic [3:0]    flags_q
);
  import falu_pkg::*;

  op_e          op;
  cls_e         cls;
  logic         wr_res;
  logic [DW-1:0] add_x, add_y, add_sum, log_res, res_sel;
  logic         add_cin, add_cout, add_ovf;
  logic         n_bit, z_bit;

  assign op = op_e'(op_code);

  // operand steering for the shared adder
  always_comb begin
    add_x   = opnd_a;
    add_y   = opnd_b;
    add_cin = 1'b0;
    cls     = CLS_NONE;
    wr_res  = 1'b0;
    unique case (op)
      OP_ADD: begin cls = CLS_ARITH; wr_res = 1'b1; end
      OP_ADC: begin cls = CLS_ARITH; wr_res = 1'b1; add_cin = flags_q[FLG_C]; end
      OP_CMN: begin cls = CLS_ARITH; end
      OP_SUB: begin cls = CLS_ARITH; wr_res = 1'b1; add_y = ~opnd_b; add_cin = 1'b1; end
      OP_CMP: begin cls = CLS_ARITH; add_y = ~opnd_b; add_cin = 1'b1; end
      OP_SBC: begin cls = CLS_ARITH; wr_res = 1'b1; add_y = ~opnd_b; add_cin = flags_q[FLG_C]; end
      OP_NEG: begin cls = CLS_ARITH; wr_res = 1'b1; add_x = '0; add_y = ~opnd_b; add_cin = 1'b1; end
      OP_TST: begin cls = CLS_LOGIC; end
      OP_AND, OP_EOR, OP_ORR, OP_BIC, OP_MVN, OP_MOVI, OP_MUL: begin
        cls = CLS_LOGIC; wr_res = 1'b1;
      end
      default: ;
    endcase
  end

  falu_adder #(.W(DW)) u_adder (
    .x(add_x), .y(add_y), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  falu_logic #(.W(DW)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .res(log_res)
  );

  assign res_sel = (cls == CLS_ARITH) ? add_sum : log_res;
  assign n_bit   = res_sel[DW-1];
  assign z_bit   = ~|res_sel;

  always_comb begin
    unique case (cls)
      CLS_ARITH: flags_nxt = {n_bit, z_bit, add_cout, add_ovf};
      CLS_LOGIC: flags_nxt = {n_bit, z_bit, flags_q[FLG_C], flags_q[FLG_V]};
      default:   flags_nxt = flags_q;
    endcase
  end

  assign res_we   = op_valid & wr_res;
  assign res_data = wr_res ? res_sel : '0;

  falu_flagreg #(.FW(4)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .upd_en(op_valid && (cls != CLS_NONE)),
    .flags_in(flags_nxt), .flags_q(flags_q)
  );

  p_we_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !res_we);

  p_compare_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd5 || op_code == 5'd6 || op_code == 5'd7) |-> !res_we);

  p_logic_keeps_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 5'd7 && op_code <= LAST_CODE)
      |=> flags_q[1:0] == $past(flags_q[1:0]));

  p_unused_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > LAST_CODE) |-> !res_we ##1 flags_q == $past(flags_q));
endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;
  import falu_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] res_data;
  logic        res_we;
  logic [3:0]  flags_nxt, flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] mdl_f = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data), .res_we(res_we),
    .flags_nxt(flags_nxt), .flags_q(flags_q)
  );

  // {code, a, b}
  localparam logic [68:0] VECS [NVEC] = '{
    {5'd0,  32'hFFFF_FFFF, 32'h0000_0001},  // R1 wrap to zero
    {5'd0,  32'h7FFF_FFFF, 32'h0000_0001},  // R1 signed overflow
    {5'd1,  32'h0000_0005, 32'h0000_0006},  // R3 C clear
    {5'd0,  32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R1 carry set
    {5'd1,  32'h0000_0005, 32'h0000_0006},  // R3 C set
    {5'd2,  32'h0000_0005, 32'h0000_0005},  // R2 equal
    {5'd2,  32'h0000_0003, 32'h0000_0005},  // R2 borrow
    {5'd3,  32'h0000_000A, 32'h0000_0003},  // R4 C clear
    {5'd2,  32'h8000_0000, 32'h0000_0001},  // R2 overflow
    {5'd3,  32'h0000_000A, 32'h0000_0003},  // R4 C set
    {5'd4,  32'h1234_5678, 32'h0000_0000},  // R5 zero
    {5'd4,  32'h0000_0000, 32'h0000_0001},  // R5 one
    {5'd5,  32'h0000_0010, 32'h0000_0020},  // R6 compare
    {5'd6,  32'hFFFF_FFF0, 32'h0000_0010},  // R6 compare-negative
    {5'd0,  32'h8000_0000, 32'h8000_0000},  // R1 sets C and V
    {5'd7,  32'hF0F0_0000, 32'h0F0F_0000},  // R6 R7 test
    {5'd8,  32'hFF00_FF00, 32'hF0F0_F0F0},  // R7 and
    {5'd9,  32'hFF00_FF00, 32'hF0F0_F0F0},  // R7 eor
    {5'd10, 32'h0000_0000, 32'h0000_0000},  // R7 orr zero
    {5'd11, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R7 bic
    {5'd12, 32'h0000_0000, 32'h0000_0000},  // R7 mvn
    {5'd13, 32'hDEAD_BEEF, 32'h0000_00AB},  // R7 move
    {5'd14, 32'h0001_0000, 32'h0001_0000},  // R8 product low zero
    {5'd14, 32'hFFFF_FFFF, 32'h0000_0003},  // R8 negative product
    {5'd20, 32'h0000_0000, 32'h0000_0000},  // R11
    {5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF}   // R11
  };

  function automatic logic [36:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [3:0] f);
    logic we, c, v, ar, lg, bor;
    logic [31:0] r;
    longint ua, ub, sa, sb, s, t;
    ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
    sa = longint'($signed(a)); sb = longint'($signed(b));
    we = 0; c = f[1]; v = f[0]; ar = 0; lg = 0; r = '0; s = 0;
    case (op)
      5'd0, 5'd1, 5'd6: begin
        bor = (op == 5'd1) ? f[1] : 1'b0;
        t = ua + ub + longint'(bor); r = t[31:0]; c = t[32];
        s = sa + sb + longint'(bor); ar = 1; we = (op != 5'd6);
      end
      5'd2, 5'd3, 5'd5: begin
        bor = (op == 5'd3) ? !f[1] : 1'b0;
        r = a - b - {31'b0, bor}; c = (ua >= ub + longint'(bor));
        s = sa - sb - longint'(bor); ar = 1; we = (op != 5'd5);
      end
      5'd4: begin r = 32'd0 - b; c = (ub == 0); s = -sb; ar = 1; we = 1; end
      5'd7:  begin r = a & b; lg = 1; end
      5'd8:  begin r = a & b; lg = 1; we = 1; end
      5'd9:  begin r = a ^ b; lg = 1; we = 1; end
      5'd10: begin r = a | b; lg = 1; we = 1; end
      5'd11: begin r = a & ~b; lg = 1; we = 1; end
      5'd12: begin r = ~b; lg = 1; we = 1; end
      5'd13: begin r = b; lg = 1; we = 1; end
      5'd14: begin t = ua * ub; r = t[31:0]; lg = 1; we = 1; end
      default: ;
    endcase
    if (ar) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    if (ar || lg) return {we, r, r[31], (r == 0), c, v};
    return {1'b0, r, f};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic v, input logic [4:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
    logic [36:0] m;
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    #1;
    m = model(op, a, b, mdl_f);
    check({tag, " res_we"}, {31'b0, res_we}, {31'b0, v & m[36]});
    if (m[36]) check({tag, " res_data"}, res_data, m[35:4]);
    check({tag, " flags_nxt"}, {28'b0, flags_nxt}, {28'b0, m[3:0]});
    @(negedge clk);
    if (v) mdl_f = m[3:0];
    check({tag, " flags_q R9"}, {28'b0, flags_q}, {28'b0, mdl_f});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset flags", {28'b0, flags_q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      string tg;
      tg = $sformatf("vec%0d R%0s", i,
        (VECS[i][68:64] <= 5'd1 || VECS[i][68:64] == 5'd6) ? "1/R3" :
        (VECS[i][68:64] <= 5'd5) ? "2/R4/R5" :
        (VECS[i][68:64] <= 5'd14) ? "7/R8" : "11");
      run_op(1'b1, VECS[i][68:64], VECS[i][63:32], VECS[i][31:0], tg);
    end

    // R7: C and V both set, then logical ops must keep them
    run_op(1'b1, 5'd0, 32'h8000_0000, 32'h8000_0000, "R1 setup");
    check("R1 C and V set", {30'b0, flags_q[1:0]}, 32'd3);
    run_op(1'b1, 5'd10, 32'h0000_0001, 32'h0, "R7 orr");
    check("R7 C V kept", {30'b0, flags_q[1:0]}, 32'd3);

    // R12 / R9: idle cycle with an add presented
    run_op(1'b0, 5'd0, 32'hFFFF_FFFF, 32'h1, "R12 idle add");
    check("R9 idle hold", {28'b0, flags_q}, {28'b0, mdl_f});

    // R6: compare never writes a result
    run_op(1'b1, 5'd5, 32'h7, 32'h7, "R6 cmp equal");
    check("R6 cmp Z C", {28'b0, flags_q}, 32'h6);

    // R11: undefined code leaves flags alone
    run_op(1'b1, 5'd15, 32'h0, 32'h0, "R11 code15");
    check("R11 flags kept", {28'b0, flags_q}, 32'h6);

    // R10: reset mid-run
    rst_n = 1'b0; #1;
    check("R10 async reset", {28'b0, flags_q}, 32'd0);
    @(negedge clk); rst_n = 1'b1; mdl_f = '0;
    run_op(1'b1, 5'd1, 32'h1, 32'h1, "R3 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule